// File: doc/BRIEF.md
# Lowest-Priority Interrupt Target Selector

This block decides which processor core takes an incoming interrupt. Each request arrives with a pool mask and a priority level. The pool mask has one bit per core and marks the cores that may receive the interrupt. Every core reports two things: whether it can accept an interrupt now, and the priority it is currently running at.

The selector first keeps the cores that are in the pool, are ready, and run below the interrupt's level. From those it picks the core running at the lowest priority. A find-first-one stage then settles any tie, so exactly one core is granted.

One cycle after a request, the block presents a valid strobe, a one-hot grant and the binary number of the chosen core. If no core qualifies, it raises a no-target flag instead. Upstream logic can then requeue the interrupt. The block never waits and never stalls.

Top module: `lp_irq_router`

## Requirements
- R1: Core i is a candidate only when req_pool[i] is 1, core_ready[i] is 1 and its running priority is strictly less than req_prio. Core i's priority sits in core_prio[i*8 +: 8] and is compared as an unsigned number.
- R2: Among the candidates, the granted core is one whose running priority is the smallest. A smaller value means a lower priority.
- R3: When several candidates share that smallest priority, the one with the lowest core number is granted.
- R4: When a target exists, out_grant has exactly one bit set.
- R5: When a target exists, out_core equals the bit position of the set bit in out_grant.
- R6: When no candidate exists, the result cycle shows out_grant all zeros, out_core 0 and out_none 1.
- R7: Each cycle in which req_valid is 1 produces one result on the next cycle, with out_valid 1 for that single cycle. Back-to-back requests each get their own result.
- R8: In a cycle with out_valid 0, out_grant is zero, out_core is 0 and out_none is 0.
- R9: While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An interrupt request is present this cycle |
| req_pool | input | 64 | Eligible cores, one bit per core |
| req_prio | input | 8 | Priority level of the interrupt |
| core_ready | input | 64 | Per-core flag: the core can accept an interrupt |
| core_prio | input | 512 | Running priority of each core, 8 bits per core, core i at bits i*8 +: 8 |
| out_valid | output | 1 | A result is present this cycle |
| out_grant | output | 64 | One-hot grant of the chosen core |
| out_core | output | 6 | Number of the chosen core |
| out_none | output | 1 | No core could take the interrupt |

## Verification
Directed patterns cover these cases:
- A single candidate, which shows that masking works.
- Equal priorities, which shows the lowest number winning the tie.
- A lowest priority held by a high-numbered core, which shows the comparison overriding plain first-set-bit order.
- Cores running exactly at the interrupt level, which tests the strict-less-than bound.
- Empty pools and cores that are not ready, which must give no target.
- The edge values 0 and 255 for the interrupt level.

After the directed cases, long random runs mix sparse and dense pools, narrow priority ranges that force ties, idle gaps and back-to-back requests. A behavioural model in the bench scans the priority levels upward, so each cycle's result is checked against that model.

// File: rtl/lp_irq_router.sv
module lp_irq_router #(
  parameter int NCORE = 64,
  parameter int PW    = 8,
  localparam int IW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [NCORE-1:0]    req_pool,
  input  logic [PW-1:0]       req_prio,
  input  logic [NCORE-1:0]    core_ready,
  input  logic [NCORE*PW-1:0] core_prio,
  output logic                out_valid,
  output logic [NCORE-1:0]    out_grant,
  output logic [IW-1:0]       out_core,
  output logic                out_none
);

  logic [NCORE-1:0] below, cand, at_min, first;
  logic [PW-1:0]    min_p;
  logic [IW-1:0]    enc;
  logic             any;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    assign below[i]  = core_prio[i*PW +: PW] < req_prio;
    assign at_min[i] = cand[i] && (core_prio[i*PW +: PW] == min_p);
  end

  assign cand  = req_pool & core_ready & below;
  assign any   = |cand;
  assign first = at_min & (~at_min + 1'b1);

  always_comb begin
    min_p = '1;
    for (int i = 0; i < NCORE; i++)
      if (cand[i] && core_prio[i*PW +: PW] < min_p) min_p = core_prio[i*PW +: PW];
  end

  always_comb begin
    enc = '0;
    for (int i = 0; i < NCORE; i++)
      if (first[i]) enc = enc | IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_grant <= '0;
      out_core  <= '0;
      out_none  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      out_grant <= req_valid ? first : '0;
      out_core  <= (req_valid && any) ? enc : '0;
      out_none  <= req_valid && !any;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_none) |-> $onehot(out_grant)); // R4
  AST_NONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_none |-> (out_grant == '0 && out_core == '0)); // R6
  AST_CORE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_none) |-> out_grant[out_core]); // R5
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_grant == '0 && !out_none && out_core == '0)); // R8
  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && any) |=> ((out_grant & $past(req_pool & core_ready)) != '0)); // R1

endmodule

// File: tb/lp_irq_router_test.sv
module lp_irq_router_test;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [N-1:0] req_pool = '0;
  logic [7:0]   req_prio = '0;
  logic [N-1:0] core_ready = '0;
  logic [N*8-1:0] core_prio = '0;
  logic         out_valid;
  logic [N-1:0] out_grant;
  logic [5:0]   out_core;
  logic         out_none;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  lp_irq_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pool(req_pool),
    .req_prio(req_prio), .core_ready(core_ready), .core_prio(core_prio),
    .out_valid(out_valid), .out_grant(out_grant), .out_core(out_core), .out_none(out_none)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: scan priority levels upward, cores upward within a level.
  task automatic step(input bit v);
    int win;
    logic [N-1:0] eg;
    req_valid = v;
    win = -1;
    for (int p = 0; p < int'(req_prio) && win < 0; p++)
      for (int c = 0; c < N && win < 0; c++)
        if (req_pool[c] && core_ready[c] && int'(core_prio[c*8 +: 8]) == p) win = c;
    eg = '0;
    if (v && win >= 0) eg[win] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 out_valid", 64'(out_valid), 64'(v));
    check("R1/R2/R3 out_grant", out_grant, eg);
    check("R5 out_core", 64'(out_core), (v && win >= 0) ? 64'(win) : 64'd0);
    check("R6 out_none", 64'(out_none), 64'(v && win < 0));
    if (!v) check("R8 idle grant", out_grant, 64'd0);
    if (v && win >= 0) check("R4 onehot", 64'($countones(out_grant)), 64'd1);
  endtask

  task automatic set_all(input logic [7:0] p);
    for (int c = 0; c < N; c++) core_prio[c*8 +: 8] = p;
  endtask

  initial begin
    #20;
    check("R9 reset valid", 64'(out_valid), 64'd0);
    check("R9 reset grant", out_grant, 64'd0);
    check("R9 reset core/none", {57'd0, out_core, out_none}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 single candidate
    req_pool = 64'h0000_0100_0000_0000; core_ready = '1; set_all(8'd3); req_prio = 8'd10;
    step(1'b1);
    // R3 ties: all equal, lowest wins
    req_pool = '1; step(1'b1);
    // R2 lowest priority held by a high core
    core_prio[63*8 +: 8] = 8'd1; step(1'b1);
    // R1 not-ready core skipped
    core_ready[63] = 1'b0; step(1'b1);
    // R1 strict bound: cores at exactly req level are not candidates
    set_all(8'd10); step(1'b1);
    core_prio[40*8 +: 8] = 8'd9; step(1'b1);
    // R6 empty pool
    req_pool = '0; step(1'b1);
    // R6 req_prio 0 never has a target
    req_pool = '1; set_all(8'd0); req_prio = 8'd0; step(1'b1);
    // R1 edge 255 with core at 254
    set_all(8'd255); core_prio[17*8 +: 8] = 8'd254; req_prio = 8'd255; step(1'b1);
    // R8 idle
    step(1'b0);
    step(1'b0);

    // R7 random, back-to-back and gaps
    for (int n = 0; n < 4000; n++) begin
      int mode;
      mode = n % 4;
      req_pool   = {$urandom, $urandom};
      core_ready = {$urandom, $urandom};
      if (mode == 1) begin req_pool = req_pool & {$urandom, $urandom}; core_ready = core_ready | {$urandom, $urandom}; end
      for (int c = 0; c < N; c++)
        core_prio[c*8 +: 8] = (mode == 2) ? 8'($urandom_range(2)) : 8'($urandom);
      req_prio = (mode == 2) ? 8'($urandom_range(3)) : 8'($urandom);
      step(($urandom_range(4) != 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule